// File: doc/BRIEF.md
# Integer Add/AND Execute Unit with Signed-Overflow Trap

This combinational execute slice serves a 32-bit RISC core. It takes the fetched instruction word and the two source operand values already read from the register file. It decodes four arithmetic forms and two bitwise-AND forms, and builds the second operand from the immediate field when the form calls for one. It produces the result, the index of the register to write, a write strobe and an overflow trap flag.

The register forms send their result to the register named in bits 15..11. The immediate forms send it to the register named in bits 20..16. The signed and unsigned additions produce the same wrapped sum. Only the signed forms check for two's-complement overflow. When an overflow occurs, the trap flag rises and the register write is withheld. The register file, the pipeline stages and the trap vectoring all sit outside this block.

Top module: `ala_unit`

## Requirements
- R1: Opcode (bits 31..26) 000000 with function code (bits 5..0) 100000 and bits 10..6 zero adds rs_val_i and rt_val_i, wraps the sum modulo 2^32, drives it on result_o, and drives dest_o with bits 15..11.
- R2: Opcode 000000 with function code 100001 and bits 10..6 zero gives the same wrapped sum and destination as R1, and ovf_o is never asserted for it.
- R3: Opcode 001000 (signed) and 001001 (unsigned) add rs_val_i to bits 15..0 sign-extended to 32 bits. dest_o is bits 20..16. The unsigned immediate form never asserts ovf_o.
- R4: Opcode 000000 with function code 100100 and bits 10..6 zero gives rs_val_i AND rt_val_i with dest_o = bits 15..11. Opcode 001100 gives rs_val_i AND bits 15..0 zero-extended, with dest_o = bits 20..16. Neither AND form asserts ovf_o.
- R5: For the signed forms (R1 and opcode 001000), ovf_o is 1 exactly when both addends have the same sign bit and the sum's sign bit differs from it. When ovf_o is 1, wr_en_o is 0 and result_o still shows the wrapped sum.
- R6: A recognised form whose destination index is 0 drives wr_en_o low. ovf_o is unaffected by the destination.
- R7: Any other encoding, including an R-type word with nonzero bits 10..6, drives result_o, dest_o, wr_en_o and ovf_o all to 0.
- R8: A recognised form with no overflow and a nonzero destination drives wr_en_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register selected by bits 25..21 |
| rt_val_i | input | 32 | Value of the register selected by bits 20..16 |
| result_o | output | 32 | Computed result |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write strobe |
| ovf_o | output | 1 | Signed overflow trap |

## Verification
The assertions are immediate checks inside the combinational logic. They rely on instr_i and the operands being settled, known values whenever they are evaluated, and they skip evaluation while any input is unknown. The bench drives every stimulus away from the clock edge and lets the logic settle before it samples. It sweeps each form over operand and immediate sets that include both sign boundaries, all-ones and zero. It covers zero and nonzero destinations, and adds a handful of encodings that lie just beside the recognised ones.

// File: rtl/ala_pkg.sv
package ala_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001100;
  localparam logic [FN_W-1:0]  FN_ADD    = 6'b100000;
  localparam logic [FN_W-1:0]  FN_ADDU   = 6'b100001;
  localparam logic [FN_W-1:0]  FN_AND    = 6'b100100;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_AND  = 2'd2
  } ala_op_e;

  typedef struct packed {
    ala_op_e          op;
    logic             trap_en;  // signed add form
    logic             use_imm;
    logic             imm_zext;
    logic [REG_W-1:0] dest;
  } ala_dec_t;
endpackage

// File: rtl/ala_decode.sv
module ala_decode
  import ala_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [4:0]       shamt_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic [REG_W-1:0] rd_i,
  output ala_dec_t         dec_o
);
  always_comb begin
    dec_o = '{op: OP_NONE, trap_en: 1'b0, use_imm: 1'b0, imm_zext: 1'b0, dest: '0};
    unique case (opc_i)
      OPC_RTYPE: begin
        if (shamt_i == '0) begin
          unique case (fn_i)
            FN_ADD:  dec_o = '{op: OP_ADD, trap_en: 1'b1, use_imm: 1'b0, imm_zext: 1'b0, dest: rd_i};
            FN_ADDU: dec_o = '{op: OP_ADD, trap_en: 1'b0, use_imm: 1'b0, imm_zext: 1'b0, dest: rd_i};
            FN_AND:  dec_o = '{op: OP_AND, trap_en: 1'b0, use_imm: 1'b0, imm_zext: 1'b0, dest: rd_i};
            default: ;
          endcase
        end
      end
      OPC_ADDI:  dec_o = '{op: OP_ADD, trap_en: 1'b1, use_imm: 1'b1, imm_zext: 1'b0, dest: rt_i};
      OPC_ADDIU: dec_o = '{op: OP_ADD, trap_en: 1'b0, use_imm: 1'b1, imm_zext: 1'b0, dest: rt_i};
      OPC_ANDI:  dec_o = '{op: OP_AND, trap_en: 1'b0, use_imm: 1'b1, imm_zext: 1'b1, dest: rt_i};
      default: ;
    endcase
  end
endmodule

// File: rtl/ala_imm_ext.sv
module ala_imm_ext #(
  parameter int IMM_W = 16,
  parameter int XLEN  = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             zext_i,
  output logic [XLEN-1:0]  imm_o
);
  localparam int PAD_W = XLEN - IMM_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic [PAD_W-1:0] pad;
      assign pad   = zext_i ? '0 : {PAD_W{imm_i[IMM_W-1]}};
      assign imm_o = {pad, imm_i};
    end else begin : g_trunc
      logic unused_zext;
      assign unused_zext = zext_i;
      assign imm_o = imm_i[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/ala_datapath.sv
module ala_datapath
  import ala_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ala_op_e         op_i,
  input  logic            trap_en_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] sum;
  logic            sign_flip;

  assign sum       = a_i + b_i;
  assign sign_flip = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        res_o = sum;
        ovf_o = trap_en_i & sign_flip;
      end
      OP_AND:  res_o = a_i & b_i;
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i})) begin
      AST_AND_NO_OVERFLOW: assert (!(op_i == OP_AND && ovf_o)) else $error("and raised ovf"); // R4
      AST_NONE_ZERO_RES: assert (!(op_i == OP_NONE && res_o != '0)) else $error("idle result"); // R7
    end
  end
endmodule

// File: rtl/ala_unit.sv
module ala_unit
  import ala_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    rs_val_i,
  input  logic [XLEN-1:0]    rt_val_i,
  output logic [XLEN-1:0]    result_o,
  output logic [REG_W-1:0]   dest_o,
  output logic               wr_en_o,
  output logic               ovf_o
);
  ala_dec_t        dec;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic            unused_rs_idx;

  assign unused_rs_idx = ^instr_i[25:21];

  ala_decode u_dec (
    .opc_i   (instr_i[31:26]),
    .fn_i    (instr_i[5:0]),
    .shamt_i (instr_i[10:6]),
    .rt_i    (instr_i[20:16]),
    .rd_i    (instr_i[15:11]),
    .dec_o   (dec)
  );

  ala_imm_ext #(.IMM_W(IMM_W), .XLEN(XLEN)) u_imm (
    .imm_i  (instr_i[IMM_W-1:0]),
    .zext_i (dec.imm_zext),
    .imm_o  (imm_ext)
  );

  assign opnd_b = dec.use_imm ? imm_ext : rt_val_i;

  ala_datapath #(.XLEN(XLEN)) u_dp (
    .op_i      (dec.op),
    .trap_en_i (dec.trap_en),
    .a_i       (rs_val_i),
    .b_i       (opnd_b),
    .res_o     (result_o),
    .ovf_o     (ovf_o)
  );

  assign dest_o  = dec.dest;
  assign wr_en_o = (dec.op != OP_NONE) && !ovf_o && (dec.dest != '0);

  always_comb begin
    if (!$isunknown({instr_i, rs_val_i, rt_val_i})) begin
      AST_NO_WRITE_ON_TRAP: assert (!(wr_en_o && ovf_o)) else $error("write during trap"); // R5
      AST_ZERO_DEST_NO_WRITE: assert (!(wr_en_o && dest_o == '0)) else $error("write to index 0"); // R6
      AST_OVF_SIGNED_ONLY: assert (!(ovf_o && !dec.trap_en)) else $error("unsigned form trapped"); // R2
      AST_UNKNOWN_QUIET: assert (!(dec.op == OP_NONE && (wr_en_o || ovf_o || dest_o != '0))) else $error("unknown encoding active"); // R7
    end
  end
endmodule

// File: tb/tb_ala_unit.sv
module tb_ala_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr, rs_v, rt_v, res;
  logic [4:0]  dest;
  logic        wr_en, ovf;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ala_unit dut (
    .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v),
    .result_o(res), .dest_o(dest), .wr_en_o(wr_en), .ovf_o(ovf)
  );

  logic [31:0] opnd_pool [8] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000,
                                 32'hffff_ffff, 32'hffff_8000, 32'h0000_ffff, 32'h1234_5678};
  logic [15:0] imm_pool [6] = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};

  function automatic logic [31:0] mk_r(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] mk_i(input logic [5:0] opc, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {opc, rs, rt, imm};
  endfunction

  // Independent model built from the requirement text.
  task automatic apply_check(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [5:0]  opc = ins[31:26];
    logic [5:0]  fn  = ins[5:0];
    bit          rform = (opc == 6'd0) && (ins[10:6] == 5'd0);
    bit          is_add = 0, is_and = 0, signed_f = 0, use_imm = 0;
    logic [31:0] opb, e_res = '0;
    logic [4:0]  e_dest = '0;
    bit          e_ovf = 0, e_wr = 0;
    longint      s;
    string       tag;
    if (rform && fn == 6'b100000) begin is_add = 1; signed_f = 1; tag = "R1"; end
    else if (rform && fn == 6'b100001) begin is_add = 1; tag = "R2"; end
    else if (rform && fn == 6'b100100) begin is_and = 1; tag = "R4"; end
    else if (opc == 6'b001000) begin is_add = 1; signed_f = 1; use_imm = 1; tag = "R3"; end
    else if (opc == 6'b001001) begin is_add = 1; use_imm = 1; tag = "R3"; end
    else if (opc == 6'b001100) begin is_and = 1; use_imm = 1; tag = "R4"; end
    else tag = "R7";
    if (use_imm) opb = is_and ? {16'h0, ins[15:0]} : {{16{ins[15]}}, ins[15:0]};
    else opb = b;
    if (is_add || is_and) begin
      e_dest = use_imm ? ins[20:16] : ins[15:11];
      if (is_add) begin
        s = longint'($signed(a)) + longint'($signed(opb));
        e_res = a + opb;
        e_ovf = signed_f && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end else e_res = a & opb;
      e_wr = !e_ovf && (e_dest != 5'd0);
      if (e_ovf) tag = {tag, "/R5"};
      else if (e_dest == 5'd0) tag = {tag, "/R6"};
      else tag = {tag, "/R8"};
    end
    @(negedge clk);
    instr = ins; rs_v = a; rt_v = b;
    #1;
    checks++;
    if (res !== e_res || dest !== e_dest || wr_en !== e_wr || ovf !== e_ovf) begin
      fails++;
      $display("FAIL %s instr=%h a=%h b=%h got res=%h dest=%0d wr=%b ovf=%b exp res=%h dest=%0d wr=%b ovf=%b",
               tag, ins, a, b, res, dest, wr_en, ovf, e_res, e_dest, e_wr, e_ovf);
    end
  endtask

  initial begin
    instr = '0; rs_v = '0; rt_v = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // all-zero word is not a recognised form: R7
    apply_check(32'h0, 32'h0, 32'h0);
    foreach (opnd_pool[i]) foreach (opnd_pool[j]) begin
      for (int d = 0; d < 3; d++) begin
        logic [4:0] rd = (d == 0) ? 5'd0 : (d == 1) ? 5'd3 : 5'd31;
        apply_check(mk_r(5'd1, 5'd2, rd, 5'd0, 6'b100000), opnd_pool[i], opnd_pool[j]); // R1
        apply_check(mk_r(5'd1, 5'd2, rd, 5'd0, 6'b100001), opnd_pool[i], opnd_pool[j]); // R2
        apply_check(mk_r(5'd1, 5'd2, rd, 5'd0, 6'b100100), opnd_pool[i], opnd_pool[j]); // R4
      end
    end
    foreach (opnd_pool[i]) foreach (imm_pool[k]) begin
      for (int d = 0; d < 2; d++) begin
        logic [4:0] rt = (d == 0) ? 5'd0 : 5'd17;
        apply_check(mk_i(6'b001000, 5'd4, rt, imm_pool[k]), opnd_pool[i], 32'hdead_beef); // R3
        apply_check(mk_i(6'b001001, 5'd4, rt, imm_pool[k]), opnd_pool[i], 32'hdead_beef); // R3
        apply_check(mk_i(6'b001100, 5'd4, rt, imm_pool[k]), opnd_pool[i], 32'hdead_beef); // R4
      end
    end
    // neighbours of recognised encodings: R7
    apply_check(mk_r(5'd1, 5'd2, 5'd3, 5'd1, 6'b100000), 32'h5, 32'h6);
    apply_check(mk_r(5'd1, 5'd2, 5'd3, 5'd16, 6'b100100), 32'hf, 32'hf);
    apply_check(mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100010), 32'h5, 32'h6);
    apply_check(mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100101), 32'h5, 32'h6);
    apply_check(mk_i(6'b001010, 5'd1, 5'd2, 16'h1), 32'h5, 32'h6);
    apply_check(mk_i(6'b001101, 5'd1, 5'd2, 16'hff), 32'h5, 32'h6);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule